// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory translation table of two levels. A request first goes through a low-address relocation step: any address under 32 MB has a process relocation offset added to it, and every later step works on the relocated value. If address translation is switched off, the relocated address is handed back as the physical address with full access, and no memory is read. If translation is on, the walker reads one word from a 16 KB first-level table through a single-beat read port. That word gives either a 1 MB section, a pointer to a coarse second-level table, or a fault. For a coarse pointer, a second word is read, and it describes a 64 KB, 4 KB or 1 KB page, or a fault.

The result is held on the outputs and marked by a single-cycle `done` pulse. It gives the physical address, a 2-bit access-permission field and a 4-bit domain number, or a fault flag with a 4-bit code. A permission checker downstream uses these values. The block accepts one request at a time and caches nothing.

Top module: `xlat_walker`

## Requirements
- R1: A request address below 0x0200_0000 has `pid_offset` added to it, modulo 2^32. Any other address is left as it is. The relocated value is the one used for all translation.
- R2: With `mmu_on` low, `done` rises in the cycle after acceptance and no read is issued. `pa` equals the relocated address, `ap` is 2'b11, `domain` is 0 and `fault` is 0.
- R3: The first-level read address is (`ttb` AND 0xFFFF_C000) OR ((VA >> 18) AND 0x3FFC), where VA is the relocated address.
- R4: If a first-level word has bits [1:0] equal to 0 or 3, the walk ends after exactly one read with `fault`=1 and `fault_code`=5.
- R5: If a first-level word has bits [1:0] equal to 2 (section), the walk ends after one read. `pa` is {word[31:20], VA[19:0]}, `ap` is word[11:10] and `domain` is word[8:5].
- R6: If a first-level word has bits [1:0] equal to 1 (coarse), a second read follows at (word AND 0xFFFF_FC00) OR ((VA >> 10) AND 0x3FC). `domain` is taken from word[8:5] of the first-level word, for pages and for page faults.
- R7: If a second-level word has bits [1:0] equal to 0, the walk ends with `fault`=1 and `fault_code`=7.
- R8: A second-level type of 1 (64 KB page) gives `pa` = {word[31:16], VA[15:0]}. `ap` is word[5+2k:4+2k], where k = VA[15:14].
- R9: A second-level type of 2 (4 KB page) gives `pa` = {word[31:12], VA[11:0]}. `ap` is word[5+2k:4+2k], where k = VA[11:10].
- R10: A second-level type of 3 (1 KB page) gives `pa` = {word[31:10], VA[9:0]}. `ap` is word[5:4].
- R11: `rd_valid` and `rd_addr` stay steady until `rd_ready` is seen. `done` is high for one cycle only. `req_ready` is high only while idle, and a request raised while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker is idle and will accept a request |
| mmu_on | input | 1 | Translation enable; low selects flat mapping |
| ttb | input | 32 | First-level table base; bits [13:0] are ignored |
| pid_offset | input | 32 | Relocation offset for low addresses |
| rd_valid | output | 1 | Table read request |
| rd_addr | output | 32 | Word address of the table read |
| rd_ready | input | 1 | Read completes this cycle; `rd_data` is valid |
| rd_data | input | 32 | Descriptor word returned |
| done | output | 1 | One-cycle pulse marking a finished walk |
| fault | output | 1 | The finished walk hit a translation fault |
| fault_code | output | 4 | 5 for a first-level fault, 7 for a second-level fault |
| pa | output | 32 | Translated physical address |
| ap | output | 2 | Access-permission field |
| domain | output | 4 | Domain number |

## Verification
The assertions assume that `ttb`, `mmu_on` and `pid_offset` stay unchanged while a walk is in progress, and that `rd_data` is valid in any cycle where `rd_valid` and `rd_ready` are both high. The bench sets these inputs only between walks, while the walker is idle. Its memory model returns a word that is a pure function of `rd_addr`, so the returned data is always defined. Stalls are produced by holding `rd_ready` low for a set number of cycles, and the read address must stay fixed during a stall.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [1:0] {WS_IDLE, WS_L1, WS_L2, WS_DONE} walk_state_t;

  localparam logic [3:0] FLT_SECTION = 4'd5;
  localparam logic [3:0] FLT_PAGE    = 4'd7;

  // first-level word address: 16 KB aligned base plus VA[31:20] word index
  function automatic logic [31:0] l1_word_addr(input logic [31:0] base, input logic [31:0] va);
    return {base[31:14], va[31:20], 2'b00};
  endfunction

  // second-level word address: 1 KB aligned coarse table plus VA[19:12] word index
  function automatic logic [31:0] l2_word_addr(input logic [31:0] l1w, input logic [31:0] va);
    return {l1w[31:10], va[19:12], 2'b00};
  endfunction

  // pick one of four sub-page permission pairs at bits [11:4]
  function automatic logic [1:0] subpage_ap(input logic [31:0] w, input logic [1:0] sel);
    logic [1:0] r;
    case (sel)
      2'd0:    r = w[5:4];
      2'd1:    r = w[7:6];
      2'd2:    r = w[9:8];
      default: r = w[11:10];
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xw_reloc.sv
module xw_reloc #(
  parameter int          VA_W  = 32,
  parameter logic [31:0] LIMIT = 32'h0200_0000
) (
  input  logic [VA_W-1:0] va_in,
  input  logic [VA_W-1:0] offset,
  output logic [VA_W-1:0] va_out
);
  localparam logic [VA_W-1:0] LIM = LIMIT[VA_W-1:0];
  always_comb va_out = (va_in < LIM) ? va_in + offset : va_in;
endmodule

// File: rtl/xw_l1_decode.sv
module xw_l1_decode
  import xw_pkg::*;
(
  input  logic [31:0] word,
  input  logic [31:0] va,
  output logic        is_fault,
  output logic        is_section,
  output logic        is_coarse,
  output logic [31:0] sec_pa,
  output logic [1:0]  sec_ap,
  output logic [3:0]  dom
);
  always_comb begin
    is_section = (word[1:0] == 2'b10);
    is_coarse  = (word[1:0] == 2'b01);
    is_fault   = !(is_section || is_coarse);
    sec_pa     = {word[31:20], va[19:0]};
    sec_ap     = word[11:10];
    dom        = word[8:5];
  end
endmodule

// File: rtl/xw_l2_decode.sv
module xw_l2_decode
  import xw_pkg::*;
(
  input  logic [31:0] word,
  input  logic [31:0] va,
  output logic        is_fault,
  output logic [31:0] pg_pa,
  output logic [1:0]  pg_ap
);
  always_comb begin
    is_fault = 1'b0;
    pg_pa    = '0;
    pg_ap    = '0;
    case (word[1:0])
      2'b01: begin
        pg_pa = {word[31:16], va[15:0]};
        pg_ap = subpage_ap(word, va[15:14]);
      end
      2'b10: begin
        pg_pa = {word[31:12], va[11:0]};
        pg_ap = subpage_ap(word, va[11:10]);
      end
      2'b11: begin
        pg_pa = {word[31:10], va[9:0]};
        pg_ap = word[5:4];
      end
      default: is_fault = 1'b1;
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  output logic        req_ready,
  input  logic        mmu_on,
  input  logic [31:0] ttb,
  input  logic [31:0] pid_offset,
  output logic        rd_valid,
  output logic [31:0] rd_addr,
  input  logic        rd_ready,
  input  logic [31:0] rd_data,
  output logic        done,
  output logic        fault,
  output logic [3:0]  fault_code,
  output logic [31:0] pa,
  output logic [1:0]  ap,
  output logic [3:0]  domain
);
  walk_state_t state;
  logic [31:0] va_q, l1w_q, va_rel;

  // decoder outputs
  logic        l1_flt, l1_sec, l1_crs;
  logic [31:0] l1_pa;
  logic [1:0]  l1_ap;
  logic [3:0]  l1_dom;
  logic        l2_flt;
  logic [31:0] l2_pa;
  logic [1:0]  l2_ap;

  xw_reloc #(.VA_W(32), .LIMIT(RELOC_LIMIT)) u_reloc (
    .va_in(req_va), .offset(pid_offset), .va_out(va_rel));

  xw_l1_decode u_l1 (
    .word(rd_data), .va(va_q), .is_fault(l1_flt), .is_section(l1_sec),
    .is_coarse(l1_crs), .sec_pa(l1_pa), .sec_ap(l1_ap), .dom(l1_dom));

  xw_l2_decode u_l2 (
    .word(rd_data), .va(va_q), .is_fault(l2_flt), .pg_pa(l2_pa), .pg_ap(l2_ap));

  // named events
  logic req_fire, flat_fire, l1_fire, l2_fire;
  logic l1_fault_fire, section_fire, coarse_fire;
  assign req_ready     = (state == WS_IDLE);
  assign req_fire      = req_ready && req_valid;
  assign flat_fire     = req_fire && !mmu_on;
  assign l1_fire       = (state == WS_L1) && rd_ready;
  assign l2_fire       = (state == WS_L2) && rd_ready;
  assign l1_fault_fire = l1_fire && l1_flt;
  assign section_fire  = l1_fire && l1_sec;
  assign coarse_fire   = l1_fire && l1_crs;

  assign rd_valid = (state == WS_L1) || (state == WS_L2);
  assign rd_addr  = (state == WS_L2) ? l2_word_addr(l1w_q, va_q) : l1_word_addr(ttb, va_q);
  assign done     = (state == WS_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= WS_IDLE;
      va_q       <= '0;
      l1w_q      <= '0;
      pa         <= '0;
      ap         <= '0;
      domain     <= '0;
      fault      <= 1'b0;
      fault_code <= '0;
    end else begin
      case (state)
        WS_IDLE: if (req_valid) begin
          va_q       <= va_rel;
          fault      <= 1'b0;
          fault_code <= '0;
          if (!mmu_on) begin
            pa     <= va_rel;
            ap     <= 2'b11;
            domain <= '0;
            state  <= WS_DONE;
          end else begin
            state <= WS_L1;
          end
        end
        WS_L1: if (rd_ready) begin
          l1w_q  <= rd_data;
          domain <= l1_dom;
          if (l1_flt) begin
            fault      <= 1'b1;
            fault_code <= FLT_SECTION;
            pa         <= '0;
            ap         <= '0;
            state      <= WS_DONE;
          end else if (l1_sec) begin
            pa    <= l1_pa;
            ap    <= l1_ap;
            state <= WS_DONE;
          end else begin
            state <= WS_L2;
          end
        end
        WS_L2: if (rd_ready) begin
          if (l2_flt) begin
            fault      <= 1'b1;
            fault_code <= FLT_PAGE;
            pa         <= '0;
            ap         <= '0;
          end else begin
            pa <= l2_pa;
            ap <= l2_ap;
          end
          state <= WS_DONE;
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R11
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !done) |=> !req_ready); // R11
  AST_FLAT_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    flat_fire |=> (done && !fault && !rd_valid && ap == 2'b11)); // R2
  AST_L1_FAULT_END: assert property (@(posedge clk) disable iff (!rst_n)
    l1_fault_fire |=> (done && fault && fault_code == FLT_SECTION)); // R4
  AST_FAULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (fault_code == FLT_SECTION || fault_code == FLT_PAGE)); // R7
  AST_SECTION_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    section_fire |=> (done && pa[19:0] == va_q[19:0])); // R5
  AST_COARSE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_fire |=> (rd_valid && !done && rd_addr[31:10] == $past(rd_data[31:10]))); // R6
  AST_L2_END: assert property (@(posedge clk) disable iff (!rst_n)
    l2_fire |=> done); // R8
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic        mmu_on = 1'b0;
  logic [31:0] ttb = 32'h0004_3FFF;
  logic [31:0] pid_offset = '0;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic        done, fault;
  logic [3:0]  fault_code;
  logic [31:0] pa;
  logic [1:0]  ap;
  logic [3:0]  domain;

  int nvec = 0;
  int nerr = 0;
  bit summary_done = 0;

  // memory model: two programmable words, anything else reads as a marker
  logic [31:0] m_a1 = '0, m_d1 = '0, m_a2 = '0, m_d2 = '0;
  assign rd_data = (rd_addr == m_a1) ? m_d1 : (rd_addr == m_a2) ? m_d2 : 32'hBAD0_BAD0;

  int stall_left = 0;
  int nreads = 0;
  logic [31:0] ra0 = '0, ra1 = '0;
  int lat;
  logic [31:0] g_pa;
  logic [1:0]  g_ap;
  logic [3:0]  g_dom, g_code;
  logic        g_fault;

  always #4 clk = ~clk;

  xlat_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
    .mmu_on(mmu_on), .ttb(ttb), .pid_offset(pid_offset), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .fault(fault), .fault_code(fault_code), .pa(pa), .ap(ap), .domain(domain));

  always @(negedge clk) begin
    if (rd_valid && stall_left > 0) begin
      rd_ready   <= 1'b0;
      stall_left <= stall_left - 1;
    end else begin
      rd_ready <= rd_valid;
    end
  end

  always @(posedge clk) begin
    if (rd_valid && rd_ready) begin
      if (nreads == 0) ra0 <= rd_addr;
      else ra1 <= rd_addr;
      nreads <= nreads + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rel(input logic [31:0] va, input logic [31:0] off);
    return (va < 32'h0200_0000) ? va + off : va;
  endfunction
  function automatic logic [31:0] exp_l1a(input logic [31:0] va);
    return (ttb & 32'hFFFF_C000) | ((va >> 18) & 32'h3FFC);
  endfunction
  function automatic logic [31:0] exp_l2a(input logic [31:0] w, input logic [31:0] va);
    return (w & 32'hFFFF_FC00) | ((va >> 10) & 32'h3FC);
  endfunction
  function automatic logic [1:0] exp_ap(input logic [31:0] w, input logic [1:0] k);
    return 2'((w >> (4 + 2 * int'(k))) & 32'h3);
  endfunction

  task automatic do_walk(input logic [31:0] va, input bit on, input logic [31:0] off, input int stalls);
    req_va = va; mmu_on = on; pid_offset = off; nreads = 0; stall_left = stalls;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    if (!done) begin nvec++; nerr++; $display("FAIL R11 walk never finished act=0 exp=1"); end
    g_pa = pa; g_ap = ap; g_dom = domain; g_fault = fault; g_code = fault_code;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 reset req_ready", 32'(req_ready), 32'd1);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset rd_valid", 32'(rd_valid), 32'd0);
  endtask

  task automatic t_flat();
    do_walk(32'h0001_2345, 1'b0, 32'h0400_0000, 0);
    chk("R2 flat latency", 32'(lat), 32'd1);
    chk("R1 low va relocated", g_pa, exp_rel(32'h0001_2345, 32'h0400_0000));
    chk("R2 no reads", 32'(nreads), 32'd0);
    chk("R2 ap full", 32'(g_ap), 32'd3);
    chk("R2 domain zero", 32'(g_dom), 32'd0);
    chk("R2 no fault", 32'(g_fault), 32'd0);
    do_walk(32'h01FF_FFFF, 1'b0, 32'h0000_1000, 0);
    chk("R1 just below limit", g_pa, 32'h0200_0FFF);
    do_walk(32'h0200_0000, 1'b0, 32'h0000_1000, 0);
    chk("R1 at limit unchanged", g_pa, 32'h0200_0000);
  endtask

  task automatic t_section();
    logic [31:0] va = 32'h4512_3456;
    m_a1 = exp_l1a(va); m_d1 = 32'h8AB0_08A2;
    do_walk(va, 1'b1, 32'h0, 0);
    chk("R3 l1 address", ra0, 32'h0004_1144);
    chk("R5 one read", 32'(nreads), 32'd1);
    chk("R5 section pa", g_pa, 32'h8AB2_3456);
    chk("R5 section ap", 32'(g_ap), 32'd2);
    chk("R5 section domain", 32'(g_dom), 32'd5);
    chk("R5 no fault", 32'(g_fault), 32'd0);
    // relocated address drives the walk
    va = exp_rel(32'h0010_0000, 32'h2000_0000);
    m_a1 = exp_l1a(va); m_d1 = 32'h3330_0C02;
    do_walk(32'h0010_0000, 1'b1, 32'h2000_0000, 0);
    chk("R1 relocated l1 index", ra0, 32'h0004_0804);
    chk("R1 relocated section pa", g_pa, 32'h3330_0000);
  endtask

  task automatic t_l1_fault();
    m_a1 = exp_l1a(32'h7000_0000); m_d1 = 32'h0000_01E0;
    do_walk(32'h7000_0000, 1'b1, 32'h0, 0);
    chk("R4 type0 fault", 32'(g_fault), 32'd1);
    chk("R4 type0 code", 32'(g_code), 32'd5);
    chk("R4 one read", 32'(nreads), 32'd1);
    m_d1 = 32'h0000_0043;
    do_walk(32'h7000_0000, 1'b1, 32'h0, 0);
    chk("R4 type3 fault", 32'(g_fault), 32'd1);
    chk("R4 type3 code", 32'(g_code), 32'd5);
  endtask

  task automatic t_page(input string tag, input logic [31:0] va, input logic [31:0] d2,
                        input logic [31:0] exp_pa, input logic [1:0] eap, input int stalls);
    m_a1 = exp_l1a(va); m_d1 = 32'h0010_0521;
    m_a2 = exp_l2a(m_d1, va); m_d2 = d2;
    do_walk(va, 1'b1, 32'h0, stalls);
    chk({tag, " R6 two reads"}, 32'(nreads), 32'd2);
    chk({tag, " R6 l2 address"}, ra1, m_a2);
    chk({tag, " R6 domain"}, 32'(g_dom), 32'd9);
    chk({tag, " pa"}, g_pa, exp_pa);
    chk({tag, " ap"}, 32'(g_ap), 32'(eap));
    chk({tag, " no fault"}, 32'(g_fault), 32'd0);
  endtask

  task automatic t_pages();
    t_page("R9 4k k1", 32'h1234_5678, 32'hCAFE_EE42, 32'hCAFE_E678, exp_ap(32'hCAFE_EE42, 2'd1), 0);
    t_page("R9 4k k3", 32'h1234_5E78, 32'hCAFE_EE42, 32'hCAFE_EE78, 2'd3, 0);
    t_page("R8 64k k3", 32'h1234_F678, 32'hBEEF_0E41, 32'hBEEF_F678, 2'd3, 0);
    t_page("R8 64k k1", 32'h1234_5A78, 32'hBEEF_0E41, 32'hBEEF_5A78, exp_ap(32'hBEEF_0E41, 2'd1), 0);
    t_page("R10 1k", 32'h1234_5678, 32'h7777_7C23, 32'h7777_7E78, 2'd2, 3);
    chk("R11 stalled latency", 32'(lat), 32'd6);
  endtask

  task automatic t_l2_fault();
    logic [31:0] va = 32'h1234_5678;
    m_a1 = exp_l1a(va); m_d1 = 32'h0010_0521;
    m_a2 = exp_l2a(m_d1, va); m_d2 = 32'h1234_0000;
    do_walk(va, 1'b1, 32'h0, 0);
    chk("R7 page fault", 32'(g_fault), 32'd1);
    chk("R7 page code", 32'(g_code), 32'd7);
    chk("R7 domain kept", 32'(g_dom), 32'd9);
  endtask

  task automatic t_busy();
    logic [31:0] va = 32'h1234_5678;
    m_a1 = exp_l1a(va); m_d1 = 32'h0010_0521;
    m_a2 = exp_l2a(m_d1, va); m_d2 = 32'hCAFE_EE42;
    req_va = va; mmu_on = 1'b1; pid_offset = '0; nreads = 0; stall_left = 4;
    req_valid = 1'b1;
    @(negedge clk);
    req_va = 32'hFFFF_FFFF;
    chk("R11 req_ready low when busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin @(negedge clk); lat++; end
    chk("R11 busy request ignored pa", pa, 32'hCAFE_E678);
    @(negedge clk);
    chk("R11 done single cycle", 32'(done), 32'd0);
    chk("R11 back to idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R11 late request not started", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_flat();
    t_section();
    t_l1_fault();
    t_pages();
    t_l2_fault();
    t_busy();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1;
      nvec++; nerr++;
      $display("FAIL R11 watchdog expired act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    end
    $finish;
  end
endmodule